// File: doc/BRIEF.md
# Load Data Aligner with Sign Extension

This block turns a 32-bit word, read from the data array or bypassed from a memory fill, into a right-justified load result. It supports byte, halfword and word loads, zero or sign extension, and a reversed byte order within the selected field. The result and a valid flag leave the block through one register stage.

Each request carries a size code, a signed flag, a byte-order flag and a two-bit byte offset. A second attribute set describes a miss that is completing. When the completion select is high, the block takes the size and flags of that miss and uses the fill offset in place of the current attributes. This lets the same steering logic finish a load whose data arrives with the fill.

There is no controller sequence in this block: every output follows from the inputs one cycle earlier. The only state is the output register, which holds either an idle value of zero or the aligned result of the previous cycle.

Top module: `ld_align_unit`

## Requirements
- R1: For a byte load (size code 00), the low byte of the result is raw bits 31:24, 23:16, 15:8 or 7:0 for offsets 00, 01, 10 and 11 respectively.
- R2: For a halfword load (size code 01), offset bit 1 high selects raw bits 15:0 and offset bit 1 low selects raw bits 31:16, placed in result bits 15:0. With the byte-order flag set, the two bytes of that field are exchanged. Offset bit 0 has no effect.
- R3: For a word load (size code 10), the result is the raw word, or the raw word with its four bytes in reverse order when the byte-order flag is set. The offset has no effect.
- R4: An unsigned byte or halfword load clears every result bit above the loaded field.
- R5: A signed byte or halfword load copies the top bit of the returned field into every higher result bit. That bit is raw bit 31, 23, 15 or 7, according to which raw byte lands in the top position.
- R6: While the completion select is high, the miss size, miss flags and fill offset decide the result, and the current access attributes have no effect.
- R7: Size code 11 is treated as a word load, and the size-error output goes high with the result.
- R8: The result, valid flag and size-error flag appear one clock after the request. They are zero after reset and in any cycle that follows a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A load result is requested this cycle |
| raw_word | input | 32 | Word from the data array or fill path |
| use_miss | input | 1 | Take the completing miss's attributes |
| cur_size | input | 2 | Current access size code |
| cur_signed | input | 1 | Current access sign-extends |
| cur_swap | input | 1 | Current access uses reversed byte order |
| cur_offset | input | 2 | Current access byte offset |
| miss_size | input | 2 | Completing miss size code |
| miss_signed | input | 1 | Completing miss sign-extends |
| miss_swap | input | 1 | Completing miss uses reversed byte order |
| fill_offset | input | 2 | Byte offset of the returning fill |
| out_data | output | 32 | Aligned, extended load result |
| out_valid | output | 1 | out_data holds a result |
| out_size_err | output | 1 | The result came from an illegal size code |

## Verification
On every cycle, the assertions check the register timing: valid follows the request by one cycle, and the outputs are zero when idle. They also check that an illegal size code raises the error flag, that unsigned narrow loads leave zero upper bits, and that signed narrow loads leave upper bits that all equal the field's top bit. Only the bench's scenarios can show that the correct raw byte reaches each lane for every offset and byte order, and that the completion select really replaces the current attributes. A reference model in the bench computes the expected word for both directed corner cases and seeded random requests.

// File: rtl/ld_align_pkg.sv
package ld_align_pkg;
    localparam int LD_LANES = 4;
    localparam int LD_OFF_W = $clog2(LD_LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } ld_size_e;

    typedef struct packed {
        ld_size_e              size;
        logic                  sgn;
        logic                  swap;
        logic [LD_OFF_W-1:0]   off;
    } ld_attr_t;
endpackage

// File: rtl/ld_attr_sel.sv
module ld_attr_sel
    import ld_align_pkg::*;
(
    input  logic                use_miss,
    input  logic [1:0]          cur_size,
    input  logic                cur_signed,
    input  logic                cur_swap,
    input  logic [LD_OFF_W-1:0] cur_offset,
    input  logic [1:0]          miss_size,
    input  logic                miss_signed,
    input  logic                miss_swap,
    input  logic [LD_OFF_W-1:0] fill_offset,
    output ld_attr_t            attr
);
    ld_attr_t cur_attr;
    ld_attr_t miss_attr;

    always_comb begin
        cur_attr.size  = ld_size_e'(cur_size);
        cur_attr.sgn   = cur_signed;
        cur_attr.swap  = cur_swap;
        cur_attr.off   = cur_offset;
        miss_attr.size = ld_size_e'(miss_size);
        miss_attr.sgn  = miss_signed;
        miss_attr.swap = miss_swap;
        miss_attr.off  = fill_offset;
        attr = use_miss ? miss_attr : cur_attr;
    end
endmodule

// File: rtl/ld_lane_steer.sv
module ld_lane_steer
    import ld_align_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W*LD_LANES-1:0] raw_word,
    input  ld_attr_t                   attr,
    output logic [BYTE_W*LD_LANES-1:0] steered
);
    localparam int DATA_W = BYTE_W * LD_LANES;
    localparam int HALF_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] lane [LD_LANES];
    logic [DATA_W-1:0] reversed;

    genvar gi;
    generate
        for (gi = 0; gi < LD_LANES; gi++) begin : g_lane
            assign lane[gi] = raw_word[gi*BYTE_W +: BYTE_W];
            assign reversed[gi*BYTE_W +: BYTE_W] = lane[LD_LANES-1-gi];
        end
    endgenerate

    logic [LD_OFF_W-1:0] byte_idx;
    logic [LD_OFF_W-1:0] half_base;
    logic [LD_OFF_W-1:0] half_hi;
    logic [LD_OFF_W-1:0] half_lo;
    logic [HALF_W-1:0]   half_val;

    always_comb begin
        byte_idx  = LD_OFF_W'(LD_LANES - 1) - attr.off;
        half_base = {attr.off[LD_OFF_W-1:1], 1'b0};
        half_hi   = LD_OFF_W'(LD_LANES - 1) - half_base;
        half_lo   = half_hi - LD_OFF_W'(1);
        half_val  = attr.swap ? {lane[half_lo], lane[half_hi]}
                              : {lane[half_hi], lane[half_lo]};
        steered   = '0;
        unique case (attr.size)
            SZ_BYTE: steered[BYTE_W-1:0] = lane[byte_idx];
            SZ_HALF: steered[HALF_W-1:0] = half_val;
            SZ_WORD,
            SZ_BAD:  steered = attr.swap ? reversed : raw_word;
        endcase
    end
endmodule

// File: rtl/ld_sign_ext.sv
module ld_sign_ext
    import ld_align_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W*LD_LANES-1:0] steered,
    input  ld_attr_t                   attr,
    output logic [BYTE_W*LD_LANES-1:0] extended
);
    localparam int DATA_W = BYTE_W * LD_LANES;
    localparam int HALF_W = 2 * BYTE_W;

    logic byte_top;
    logic half_top;

    always_comb begin
        byte_top = attr.sgn & steered[BYTE_W-1];
        half_top = attr.sgn & steered[HALF_W-1];
        unique case (attr.size)
            SZ_BYTE: extended = {{(DATA_W-BYTE_W){byte_top}}, steered[BYTE_W-1:0]};
            SZ_HALF: extended = {{(DATA_W-HALF_W){half_top}}, steered[HALF_W-1:0]};
            SZ_WORD,
            SZ_BAD:  extended = steered;
        endcase
    end
endmodule

// File: rtl/ld_align_unit.sv
module ld_align_unit
    import ld_align_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [BYTE_W*LD_LANES-1:0] raw_word,
    input  logic                       use_miss,
    input  logic [1:0]                 cur_size,
    input  logic                       cur_signed,
    input  logic                       cur_swap,
    input  logic [LD_OFF_W-1:0]        cur_offset,
    input  logic [1:0]                 miss_size,
    input  logic                       miss_signed,
    input  logic                       miss_swap,
    input  logic [LD_OFF_W-1:0]        fill_offset,
    output logic [BYTE_W*LD_LANES-1:0] out_data,
    output logic                       out_valid,
    output logic                       out_size_err
);
    localparam int DATA_W = BYTE_W * LD_LANES;
    localparam int HALF_W = 2 * BYTE_W;

    ld_attr_t          eff_attr;
    logic [DATA_W-1:0] steered;
    logic [DATA_W-1:0] aligned;

    ld_attr_sel u_sel (
        .use_miss    (use_miss),
        .cur_size    (cur_size),
        .cur_signed  (cur_signed),
        .cur_swap    (cur_swap),
        .cur_offset  (cur_offset),
        .miss_size   (miss_size),
        .miss_signed (miss_signed),
        .miss_swap   (miss_swap),
        .fill_offset (fill_offset),
        .attr        (eff_attr)
    );

    ld_lane_steer #(.BYTE_W(BYTE_W)) u_steer (
        .raw_word (raw_word),
        .attr     (eff_attr),
        .steered  (steered)
    );

    ld_sign_ext #(.BYTE_W(BYTE_W)) u_ext (
        .steered  (steered),
        .attr     (eff_attr),
        .extended (aligned)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data     <= '0;
            out_valid    <= 1'b0;
            out_size_err <= 1'b0;
        end else begin
            out_data     <= in_valid ? aligned : '0;
            out_valid    <= in_valid;
            out_size_err <= in_valid && (eff_attr.size == SZ_BAD);
        end
    end

    // R8: one-cycle latency of the valid flag
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_data == '0 && !out_size_err));
    // R7: illegal size code flagged
    a_r7_bad_size_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && eff_attr.size == SZ_BAD) |=> out_size_err);
    // R4: unsigned narrow loads have clear upper bits
    a_r4_byte_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !eff_attr.sgn && eff_attr.size == SZ_BYTE)
        |=> out_data[DATA_W-1:BYTE_W] == '0);
    a_r4_half_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !eff_attr.sgn && eff_attr.size == SZ_HALF)
        |=> out_data[DATA_W-1:HALF_W] == '0);
    // R5: signed narrow loads replicate the field's top bit
    a_r5_half_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && eff_attr.sgn && eff_attr.size == SZ_HALF)
        |=> out_data[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){out_data[HALF_W-1]}});
    a_r5_byte_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && eff_attr.sgn && eff_attr.size == SZ_BYTE)
        |=> out_data[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){out_data[BYTE_W-1]}});
endmodule

// File: tb/sim_ld_align_unit.sv
module sim_ld_align_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] raw_word = '0;
    logic        use_miss = 1'b0;
    logic [1:0]  cur_size = '0;
    logic        cur_signed = 1'b0;
    logic        cur_swap = 1'b0;
    logic [1:0]  cur_offset = '0;
    logic [1:0]  miss_size = '0;
    logic        miss_signed = 1'b0;
    logic        miss_swap = 1'b0;
    logic [1:0]  fill_offset = '0;
    logic [31:0] out_data;
    logic        out_valid;
    logic        out_size_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ld_align_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .raw_word(raw_word),
        .use_miss(use_miss), .cur_size(cur_size), .cur_signed(cur_signed),
        .cur_swap(cur_swap), .cur_offset(cur_offset), .miss_size(miss_size),
        .miss_signed(miss_signed), .miss_swap(miss_swap),
        .fill_offset(fill_offset), .out_data(out_data), .out_valid(out_valid),
        .out_size_err(out_size_err)
    );

    function automatic logic [31:0] ref_align(input logic [31:0] w,
        input logic [1:0] sz, input logic sg, input logic sw, input logic [1:0] of);
        logic [7:0] d3, d2, d1, d0, b;
        logic [15:0] h;
        d3 = w[31:24]; d2 = w[23:16]; d1 = w[15:8]; d0 = w[7:0];
        if (sz == 2'b00) begin
            case (of)
                2'd0: b = d3;
                2'd1: b = d2;
                2'd2: b = d1;
                default: b = d0;
            endcase
            return sg ? {{24{b[7]}}, b} : {24'h0, b};
        end else if (sz == 2'b01) begin
            if (of[1]) h = sw ? {d0, d1} : {d1, d0};
            else       h = sw ? {d2, d3} : {d3, d2};
            return sg ? {{16{h[15]}}, h} : {16'h0, h};
        end
        return sw ? {d0, d1, d2, d3} : w;
    endfunction

    task automatic check(input string req, input logic [31:0] exp_d,
                         input logic exp_v, input logic exp_e);
        n_checks++;
        if (out_data !== exp_d || out_valid !== exp_v || out_size_err !== exp_e) begin
            n_errors++;
            $display("FAIL %s: data=%h valid=%b err=%b expected data=%h valid=%b err=%b",
                     req, out_data, out_valid, out_size_err, exp_d, exp_v, exp_e);
        end
    endtask

    task automatic run_vec(input string req, input logic v, input logic [31:0] w,
        input logic um, input logic [1:0] cs, input logic cg, input logic cw,
        input logic [1:0] co, input logic [1:0] ms, input logic mg,
        input logic mw, input logic [1:0] fo);
        logic [31:0] e;
        logic [1:0] es;
        @(negedge clk);
        in_valid = v; raw_word = w; use_miss = um;
        cur_size = cs; cur_signed = cg; cur_swap = cw; cur_offset = co;
        miss_size = ms; miss_signed = mg; miss_swap = mw; fill_offset = fo;
        es = um ? ms : cs;
        e = um ? ref_align(w, ms, mg, mw, fo) : ref_align(w, cs, cg, cw, co);
        @(negedge clk);
        if (v) check(req, e, 1'b1, es == 2'b11);
        else   check(req, 32'h0, 1'b0, 1'b0);
    endtask

    localparam logic [31:0] PAT = 32'hF172_8304;

    initial begin
        int seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check("R8 reset", 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        // R1: byte lanes per offset, signed and unsigned
        run_vec("R1 byte off0 signed", 1, PAT, 0, 2'b00, 1, 0, 2'd0, 2'b10, 0, 0, 2'd3);
        run_vec("R1 byte off1", 1, PAT, 0, 2'b00, 1, 0, 2'd1, 2'b10, 0, 0, 2'd3);
        run_vec("R1 byte off2", 1, PAT, 0, 2'b00, 1, 1, 2'd2, 2'b10, 0, 0, 2'd3);
        run_vec("R1 byte off3", 1, PAT, 0, 2'b00, 0, 0, 2'd3, 2'b10, 0, 0, 2'd3);
        // R4: unsigned zero fill with high sign bits present
        run_vec("R4 unsigned byte", 1, 32'hFFFF_FFFF, 0, 2'b00, 0, 0, 2'd2, 2'b00, 1, 0, 2'd0);
        run_vec("R4 unsigned half", 1, 32'h8080_8080, 0, 2'b01, 0, 1, 2'd0, 2'b00, 1, 0, 2'd0);
        // R2: halfword fields, swap, offset bit 0 ignored
        run_vec("R2 half hi", 1, PAT, 0, 2'b01, 1, 0, 2'd0, 2'b00, 0, 0, 2'd0);
        run_vec("R2 half hi off bit0", 1, PAT, 0, 2'b01, 1, 0, 2'd1, 2'b00, 0, 0, 2'd0);
        run_vec("R2 half lo swap", 1, PAT, 0, 2'b01, 1, 1, 2'd2, 2'b00, 0, 0, 2'd0);
        run_vec("R2 half lo", 1, PAT, 0, 2'b01, 1, 0, 2'd3, 2'b00, 0, 0, 2'd0);
        // R5: sign from raw bits 23 and 7 via swapped halves
        run_vec("R5 sign from bit23", 1, 32'h0080_0000, 0, 2'b01, 1, 1, 2'd0, 2'b00, 0, 0, 2'd0);
        run_vec("R5 sign from bit7", 1, 32'h0000_0080, 0, 2'b01, 1, 1, 2'd2, 2'b00, 0, 0, 2'd0);
        // R3: word, offset ignored
        run_vec("R3 word", 1, PAT, 0, 2'b10, 1, 0, 2'd3, 2'b00, 0, 0, 2'd0);
        run_vec("R3 word swap", 1, PAT, 0, 2'b10, 0, 1, 2'd1, 2'b00, 0, 0, 2'd0);
        // R7: illegal size
        run_vec("R7 bad size", 1, PAT, 0, 2'b11, 1, 0, 2'd2, 2'b00, 0, 0, 2'd0);
        run_vec("R7 bad size swap miss", 1, PAT, 1, 2'b00, 0, 0, 2'd0, 2'b11, 0, 1, 2'd1);
        // R6: miss attributes replace current ones
        run_vec("R6 miss byte", 1, PAT, 1, 2'b10, 0, 1, 2'd0, 2'b00, 1, 0, 2'd2);
        run_vec("R6 miss half", 1, PAT, 1, 2'b00, 0, 0, 2'd3, 2'b01, 0, 1, 2'd0);
        // R8: idle cycle clears outputs
        run_vec("R8 idle", 0, PAT, 0, 2'b10, 0, 0, 2'd0, 2'b00, 0, 0, 2'd0);
        for (int i = 0; i < 400; i++) begin
            logic v;
            v = ($urandom % 8) != 0;
            run_vec(v ? "R6 R8 random" : "R8 random idle", v, $urandom, 1'($urandom),
                    2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                    2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule